// File: doc/BRIEF.md
# Best Pending Interrupt Selector

This block serves a single processor-facing port of an interrupt controller. Every cycle it looks at all interrupt sources, decides which are eligible to be presented to this processor, and names the eligible source with the most urgent priority. Eligibility depends on several conditions. The source must be pending and enabled, and not already active here. The global forwarding switch must be on. A shared source must also list this processor in its routing mask.

Priorities are 8-bit fields in which a smaller number is more urgent. Only a parameterised number of the upper bits take part, and the rest are treated as zero. The winner is found by a pipelined pairwise tournament. Each new input set gives a result a fixed number of cycles later, and a new result comes out every cycle. When no source is eligible, the block reports the reserved "nothing to take" ID instead of a winner.

Top module: `hp_select`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `best_vld` is 0, `best_id` is 1023 and `best_prio` is 8'hFF.
- R2: Among eligible sources, the one with the numerically smallest effective priority wins, so 0 is the most urgent value.
- R3: When eligible sources share the smallest effective priority, the one with the lowest ID wins.
- R4: The effective priority keeps only the upper `PRIO_IMPL` bits of `src_prio`. The default is 5, which zeroes bits [2:0]. Sources that differ only in the ignored bits tie, and `best_prio` always shows the ignored bits as 0.
- R5: IDs 0 to 31 belong to this processor alone and ignore routing. For an ID i of 32 or more, bit `cpu_num` of the `NUM_CPU`-bit row starting at bit (i-32)*NUM_CPU of `src_tgt` must be 1.
- R6: A source whose `src_act` bit is 1 is never selected, whatever its pending state.
- R7: A source is eligible only when both its `src_pend` bit and its `src_en` bit are 1.
- R8: While `fwd_en` is 0, nothing is eligible.
- R9: When nothing is eligible, `best_vld` is 0, `best_id` is 1023 and `best_prio` is 8'hFF.
- R10: The outputs reflect the inputs sampled 1+log2(NUM_SRC) rising edges earlier (7 at the defaults), and a fresh result appears every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwd_en | input | 1 | Global forwarding enable |
| cpu_num | input | $clog2(NUM_CPU) | Number of this processor port |
| src_pend | input | NUM_SRC | Pending flag per source |
| src_en | input | NUM_SRC | Enable flag per source |
| src_act | input | NUM_SRC | Active (or active and pending) flag per source |
| src_prio | input | NUM_SRC*8 | Priority per source, source i at bits [8i+7:8i] |
| src_tgt | input | (NUM_SRC-32)*NUM_CPU | Routing mask rows for shared sources |
| best_vld | output | 1 | A winner exists |
| best_id | output | 10 | Winning ID, or 1023 when there is none |
| best_prio | output | 8 | Effective priority of the winner, or 8'hFF |

## Verification
The bench targets ties, both exact ones and ones created only by the ignored low priority bits. A design that lets the higher ID win a tie, or that compares raw bits, reports the wrong source. It routes the same shared source with and without this processor's bit, and offers a top-priority source that is already active. A design with faulty routing decode or a missing active filter would pick those sources. Back-to-back distinct vectors expose any error in pipeline depth or any stage that holds its value: results would line up against the wrong input set.

// File: rtl/hp_sel_pkg.sv
package hp_sel_pkg;

    localparam int ID_W      = 10;
    localparam int PRIO_W    = 8;
    localparam int PRIV_IDS  = 32;
    localparam logic [ID_W-1:0]   NONE_ID   = 10'd1023;
    localparam logic [PRIO_W-1:0] IDLE_PRIO = 8'hFF;

    typedef struct packed {
        logic              vld;
        logic [PRIO_W-1:0] prio;
        logic [ID_W-1:0]   id;
    } cand_t;

    // Mask that keeps the implemented upper priority bits.
    function automatic logic [PRIO_W-1:0] prio_keep(input int impl);
        return 8'hFF << (PRIO_W - impl);
    endfunction

    // Winner of two candidates; lo holds the lower ID range and wins ties.
    function automatic cand_t pick(input cand_t lo, input cand_t hi);
        if (!hi.vld)
            return lo;
        if (!lo.vld)
            return hi;
        return (hi.prio < lo.prio) ? hi : lo;
    endfunction

endpackage

// File: rtl/hp_leaf.sv
module hp_leaf
    import hp_sel_pkg::*;
#(
    parameter int NUM_CPU   = 8,
    parameter int PRIO_IMPL = 5,
    parameter int SRC_ID    = 0,
    localparam int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fwd_en,
    input  logic               pend,
    input  logic               en,
    input  logic               act,
    input  logic [PRIO_W-1:0]  prio,
    input  logic [NUM_CPU-1:0] tgt_row,
    input  logic [CPU_W-1:0]   cpu_num,
    output cand_t              q
);
    localparam logic [PRIO_W-1:0] KEEP = prio_keep(PRIO_IMPL);

    logic  routed;
    cand_t nxt;

    always_comb begin
        routed   = tgt_row[cpu_num];
        nxt.vld  = fwd_en && pend && en && !act && routed;
        nxt.prio = prio & KEEP;
        nxt.id   = ID_W'(SRC_ID);
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= nxt;
    end
endmodule

// File: rtl/hp_node.sv
module hp_node
    import hp_sel_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  cand_t lo,
    input  cand_t hi,
    output cand_t y
);
    always_ff @(posedge clk) begin
        if (rst)
            y <= '0;
        else
            y <= pick(lo, hi);
    end
endmodule

// File: rtl/hp_select.sv
module hp_select
    import hp_sel_pkg::*;
#(
    parameter int NUM_SRC   = 64,
    parameter int NUM_CPU   = 8,
    parameter int PRIO_IMPL = 5,
    localparam int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int NUM_SHR  = NUM_SRC - PRIV_IDS,
    localparam int LEVELS   = $clog2(NUM_SRC),
    localparam int PAD      = 1 << LEVELS
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        fwd_en,
    input  logic [CPU_W-1:0]            cpu_num,
    input  logic [NUM_SRC-1:0]          src_pend,
    input  logic [NUM_SRC-1:0]          src_en,
    input  logic [NUM_SRC-1:0]          src_act,
    input  logic [NUM_SRC*PRIO_W-1:0]   src_prio,
    input  logic [NUM_SHR*NUM_CPU-1:0]  src_tgt,
    output logic                        best_vld,
    output logic [ID_W-1:0]             best_id,
    output logic [PRIO_W-1:0]           best_prio
);
    // Heap-ordered tournament: node k merges 2k and 2k+1; leaves at PAD..2*PAD-1.
    cand_t tree [1:2*PAD-1];

    genvar g;
    generate
        for (g = 0; g < PAD; g++) begin : g_leaf
            if (g < NUM_SRC) begin : g_real
                logic [NUM_CPU-1:0] row;
                if (g < PRIV_IDS) begin : g_priv
                    assign row = '1;
                end else begin : g_shr
                    assign row = src_tgt[(g-PRIV_IDS)*NUM_CPU +: NUM_CPU];
                end
                hp_leaf #(
                    .NUM_CPU  (NUM_CPU),
                    .PRIO_IMPL(PRIO_IMPL),
                    .SRC_ID   (g)
                ) u_leaf (
                    .clk    (clk),
                    .rst    (rst),
                    .fwd_en (fwd_en),
                    .pend   (src_pend[g]),
                    .en     (src_en[g]),
                    .act    (src_act[g]),
                    .prio   (src_prio[g*PRIO_W +: PRIO_W]),
                    .tgt_row(row),
                    .cpu_num(cpu_num),
                    .q      (tree[PAD+g])
                );
            end else begin : g_pad
                assign tree[PAD+g] = '0;
            end
        end

        for (g = 1; g < PAD; g++) begin : g_node
            hp_node u_node (
                .clk(clk),
                .rst(rst),
                .lo (tree[2*g]),
                .hi (tree[2*g+1]),
                .y  (tree[g])
            );
        end
    endgenerate

    always_comb begin
        best_vld  = tree[1].vld;
        best_id   = tree[1].vld ? tree[1].id   : NONE_ID;
        best_prio = tree[1].vld ? tree[1].prio : IDLE_PRIO;
    end
endmodule

// File: rtl/hp_select_chk.sv
module hp_select_chk
    import hp_sel_pkg::*;
#(
    parameter int NUM_SRC   = 64,
    parameter int NUM_CPU   = 8,
    parameter int PRIO_IMPL = 5,
    localparam int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int NUM_SHR  = NUM_SRC - PRIV_IDS,
    localparam int LAT      = 1 + $clog2(NUM_SRC),
    localparam int SW       = $clog2(NUM_SRC),
    localparam int BW       = 1 + CPU_W + 3*NUM_SRC + NUM_SRC*PRIO_W + NUM_SHR*NUM_CPU
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        fwd_en,
    input logic [CPU_W-1:0]            cpu_num,
    input logic [NUM_SRC-1:0]          src_pend,
    input logic [NUM_SRC-1:0]          src_en,
    input logic [NUM_SRC-1:0]          src_act,
    input logic [NUM_SRC*PRIO_W-1:0]   src_prio,
    input logic [NUM_SHR*NUM_CPU-1:0]  src_tgt,
    input logic                        best_vld,
    input logic [ID_W-1:0]             best_id,
    input logic [PRIO_W-1:0]           best_prio
);
    localparam logic [PRIO_W-1:0] KEEP = prio_keep(PRIO_IMPL);

    logic [BW-1:0] bundle, prev;
    logic [7:0]    same_cnt, off_cnt;
    logic [SW-1:0] bidx;

    assign bundle = {fwd_en, cpu_num, src_pend, src_en, src_act, src_prio, src_tgt};
    assign bidx   = best_id[SW-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            prev     <= '0;
            same_cnt <= '0;
            off_cnt  <= '0;
        end else begin
            prev     <= bundle;
            same_cnt <= (bundle != prev) ? 8'd0 :
                        (same_cnt < 8'(LAT)) ? same_cnt + 8'd1 : same_cnt;
            off_cnt  <= fwd_en ? 8'd0 :
                        (off_cnt < 8'(LAT)) ? off_cnt + 8'd1 : off_cnt;
        end
    end

    p_none_code_r9: assert property (@(posedge clk) disable iff (rst)
        !best_vld |-> (best_id == NONE_ID && best_prio == IDLE_PRIO));

    p_id_range_r10: assert property (@(posedge clk) disable iff (rst)
        best_vld |-> (best_id < ID_W'(NUM_SRC)));

    p_low_bits_r4: assert property (@(posedge clk) disable iff (rst)
        best_vld |-> ((best_prio & ~KEEP) == '0));

    p_fwd_off_r8: assert property (@(posedge clk) disable iff (rst)
        (off_cnt >= 8'(LAT)) |-> !best_vld);

    p_winner_live_r7: assert property (@(posedge clk) disable iff (rst)
        (same_cnt >= 8'(LAT) && best_vld) |-> (src_pend[bidx] && src_en[bidx]));

    p_not_active_r6: assert property (@(posedge clk) disable iff (rst)
        (same_cnt >= 8'(LAT) && best_vld) |-> !src_act[bidx]);
endmodule

bind hp_select hp_select_chk #(
    .NUM_SRC  (NUM_SRC),
    .NUM_CPU  (NUM_CPU),
    .PRIO_IMPL(PRIO_IMPL)
) u_chk (.*);

// File: tb/hp_select_test.sv
module hp_select_test;
    localparam int NSRC = 64;
    localparam int NCPU = 8;
    localparam int IMPL = 5;
    localparam int NSHR = NSRC - 32;
    localparam int LAT  = 7;
    localparam logic [7:0] KEEP = 8'hF8;

    logic clk = 0;
    logic rst = 1;
    logic fwd_en = 0;
    logic [2:0] cpu_num = 3'd3;
    logic [NSRC-1:0] src_pend = '0, src_en = '0, src_act = '0;
    logic [NSRC*8-1:0] src_prio = '0;
    logic [NSHR*NCPU-1:0] src_tgt = '0;
    logic best_vld;
    logic [9:0] best_id;
    logic [7:0] best_prio;

    always #10 clk = ~clk;

    hp_select #(.NUM_SRC(NSRC), .NUM_CPU(NCPU), .PRIO_IMPL(IMPL)) uut (
        .clk(clk), .rst(rst), .fwd_en(fwd_en), .cpu_num(cpu_num),
        .src_pend(src_pend), .src_en(src_en), .src_act(src_act),
        .src_prio(src_prio), .src_tgt(src_tgt),
        .best_vld(best_vld), .best_id(best_id), .best_prio(best_prio)
    );

    typedef struct {
        int         due;
        logic       v;
        logic [9:0] id;
        logic [7:0] pr;
        string      tag;
    } exp_t;

    exp_t sb[$];
    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic v, input logic [9:0] id,
                         input logic [7:0] pr);
        n_chk++;
        if (best_vld !== v || best_id !== id || best_prio !== pr) begin
            n_bad++;
            $display("FAIL %s: got vld=%0b id=%0d prio=%h, expected vld=%0b id=%0d prio=%h",
                     tag, best_vld, best_id, best_prio, v, id, pr);
        end
    endtask

    // Reference model built from the requirements.
    task automatic model(output logic v, output logic [9:0] id, output logic [7:0] pr);
        v = 0; id = 10'd1023; pr = 8'hFF;
        for (int i = 0; i < NSRC; i++) begin
            logic ok;
            logic [7:0] p;
            ok = fwd_en && src_pend[i] && src_en[i] && !src_act[i];
            if (i >= 32)
                ok = ok && src_tgt[(i-32)*NCPU + cpu_num];
            p = src_prio[i*8 +: 8] & KEEP;
            if (ok && (!v || p < pr)) begin
                v = 1; id = 10'(i); pr = p;
            end
        end
    endtask

    // Driver: apply current stimulus for one cycle and queue the expectation.
    task automatic drive(input string tag);
        exp_t e;
        logic v;
        logic [9:0] id;
        logic [7:0] pr;
        model(v, id, pr);
        e.due = cyc + LAT; e.v = v; e.id = id; e.pr = pr; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    task automatic clear();
        fwd_en = 1; src_pend = '0; src_en = '0; src_act = '0;
        src_prio = '0; src_tgt = '0;
    endtask

    task automatic put(input int id, input logic [7:0] p);
        src_pend[id] = 1; src_en[id] = 1;
        src_prio[id*8 +: 8] = p;
        if (id >= 32) src_tgt[(id-32)*NCPU + cpu_num] = 1;
    endtask

    // Monitor: pop expectations as results arrive.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t e;
                e = sb.pop_front();
                check(e.tag, e.v, e.id, e.pr);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got no completion, expected finish before timeout");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        #1 check("R1 during reset", 0, 10'd1023, 8'hFF);
        rst = 0;
        @(negedge clk);
        #1 check("R1 after reset", 0, 10'd1023, 8'hFF);

        // R2: smaller value wins, shared vs private
        clear(); put(5, 8'h80); put(40, 8'h20);
        drive("R2 smaller value wins");
        clear(); put(7, 8'h00); put(60, 8'hF0);
        drive("R2 zero most urgent");
        // R3: exact tie goes to lower ID
        clear(); put(50, 8'h30); put(10, 8'h30);
        drive("R3 tie lower id");
        clear(); put(63, 8'h10); put(33, 8'h10);
        drive("R3 tie shared ids");
        // R4: low bits ignored
        clear(); put(12, 8'h47); put(9, 8'h41);
        drive("R4 low bits tie");
        clear(); put(3, 8'h27); put(2, 8'h28);
        drive("R4 masked compare");
        // R5: routing
        clear(); put(45, 8'h00); src_tgt[(45-32)*NCPU + 3] = 0;
        src_tgt[(45-32)*NCPU + 4] = 1; put(17, 8'h80);
        drive("R5 shared not routed here");
        clear(); src_pend[20] = 1; src_en[20] = 1; src_prio[20*8 +: 8] = 8'h50;
        drive("R5 private ignores routing");
        clear(); put(45, 8'h00); put(17, 8'h80);
        drive("R5 shared routed here");
        // R6: active excluded
        clear(); put(3, 8'h00); src_act[3] = 1; put(4, 8'h60);
        drive("R6 active excluded");
        // R7: pending and enable both needed
        clear(); put(8, 8'h00); src_en[8] = 0; put(9, 8'h00); src_pend[9] = 0;
        put(11, 8'hC0);
        drive("R7 needs pend and en");
        // R8: forwarding off
        clear(); put(1, 8'h00); fwd_en = 0;
        drive("R8 forwarding off");
        // R9: nothing eligible
        clear();
        drive("R9 nothing eligible");
        // R10: back-to-back distinct results, pipelined
        for (int k = 0; k < 40; k++) begin
            clear(); put(k, 8'(8 * (k % 32)));
            drive("R10 back to back");
        end
        // Random mix
        for (int k = 0; k < 300; k++) begin
            fwd_en   = ($urandom % 10) != 0;
            cpu_num  = 3'($urandom);
            src_pend = {$urandom, $urandom};
            src_en   = {$urandom, $urandom};
            src_act  = {$urandom, $urandom} & {$urandom, $urandom};
            for (int i = 0; i < NSRC; i++)
                src_prio[i*8 +: 8] = 8'($urandom % 4) << 6 | 8'($urandom % 8);
            for (int i = 0; i < NSHR*NCPU; i += 32)
                src_tgt[i +: 32] = $urandom;
            drive("R2 R3 R4 R5 R6 R7 random");
        end
        clear(); fwd_en = 0;
        repeat (LAT + 3) @(negedge clk);
        if (sb.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL R10: got %0d unchecked results, expected 0", sb.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule